// File: doc/BRIEF.md
# Crypto Command Word Parser

This block sits behind the write port of a crypto engine's command queue. Software pushes 32-bit words one at a time. The parser collects them in a small buffer and, after every accepted write, tries to decode what it has gathered. Once the word at the front of the buffer has all the payload its opcode needs, the parser dispatches the command and empties the buffer:

- Key and IV loads become one-cycle strobes that carry their payload words.
- A data command becomes a DMA job descriptor, held until the DMA side acknowledges it.
- A store-IV command becomes a held write request with a 40-bit target address.
- A flag command becomes a one-cycle event.
- An unknown opcode becomes an invalid-command pulse.

A command that cannot complete stays in the buffer. Decoding is then tried again on the next write. This rule covers three cases: a command that is still short of payload, a key command with an unsupported setting, and a DMA or IV-store request acknowledged with an error. The cipher datapath, the DMA engine and the register bank lie outside this block.

Top module: `cmd_fifo_parser`

## Requirements
- R1: The buffer holds at most 9 words. A word written while the buffer is full is dropped, and does not overwrite any buffered word, but decoding is still retried after that write.
- R2: The opcode is header bits 31:28, with these codes: 1 load key, 2 load IV, 5 data, 6 store IV, 8 flag. Any other code pulses `bad_cmd` for one cycle after each decode attempt and leaves the buffer untouched.
- R3: A word sampled on a rising edge is decoded during the next cycle. The resulting strobe or request becomes visible after the following rising edge.
- R4: Key command fields:
  - bit 27 is the context (`key_ctx`);
  - bits 26:24 select a built-in key (`key_sel`);
  - bits 23:22 give the length code (`key_len_code`);
  - bit 20 requests encryption (`key_encrypt`);
  - bits 17:16 give the block mode, 0 for ECB and 1 for CBC (`key_cbc` = bit 16).

  A nonzero select completes with no payload and `key_data` all zero. With select zero, length codes 0, 1 and 2 need 4, 6 and 8 payload words. Payload word k appears in `key_data[32k+31:32k]`, and the unused upper words are zero.
- R5: A key command with block mode 2 or 3, or with select zero and length code 3, never completes: no strobe appears and the buffer is kept.
- R6: An IV load needs 4 payload words. It pulses `iv_valid` with context from header bits 27:26, and payload word k appears in `iv_data[32k+31:32k]`.
- R7: A data command needs 3 payload words. Its descriptor fields are:
  - `dma_len`: header bits 23:0;
  - `dma_key_ctx`: header bit 27;
  - `dma_iv_ctx`: header bits 26:25;
  - `dma_src`: word 2 in bits 31:0 and word 1 bits 31:16 in bits 47:32;
  - `dma_dst`: word 3 in bits 31:0 and word 1 bits 15:0 in bits 47:32.
- R8: `dma_valid` and its descriptor stay steady until a cycle with `dma_ack`. If `dma_ok` is high in that cycle the buffer is cleared. If it is low the command remains buffered and is dispatched again on the next decode attempt.
- R9: A store-IV command needs 1 payload word. `siv_addr` is word 1 in bits 31:0 with header bits 7:0 in bits 39:32, and `siv_ctx` is header bits 27:26. `siv_valid` follows the same held handshake as R8, using `siv_ack` and `siv_ok`.
- R10: A flag command needs no payload. It pulses `flag_valid` with `flag_irq` from header bit 27 and `flag_info` from header bits 7:0, then clears the buffer.
- R11: A successful command discards every buffered word. A word written on the same edge becomes the new word 0.
- R12: While `dma_valid` or `siv_valid` is high, writes are still appended but no decode takes place.
- R13: At most one of `key_valid`, `iv_valid`, `flag_valid` and `bad_cmd` is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word |
| key_valid | output | 1 | Key load strobe |
| key_ctx | output | 1 | Key context |
| key_sel | output | 3 | Built-in key select, 0 for explicit key |
| key_len_code | output | 2 | Key length code |
| key_encrypt | output | 1 | Encrypt direction |
| key_cbc | output | 1 | Chained block mode |
| key_data | output | 256 | Explicit key words |
| iv_valid | output | 1 | IV load strobe |
| iv_ctx | output | 2 | IV context |
| iv_data | output | 128 | IV words |
| dma_valid | output | 1 | Data job request |
| dma_ack | input | 1 | Data job acknowledge |
| dma_ok | input | 1 | Data job succeeded |
| dma_len | output | 24 | Byte length |
| dma_src | output | 48 | Source address |
| dma_dst | output | 48 | Destination address |
| dma_key_ctx | output | 1 | Key context for the job |
| dma_iv_ctx | output | 2 | IV context for the job |
| siv_valid | output | 1 | IV store request |
| siv_ack | input | 1 | IV store acknowledge |
| siv_ok | input | 1 | IV store succeeded |
| siv_ctx | output | 2 | IV context to store |
| siv_addr | output | 40 | Store target address |
| flag_valid | output | 1 | Flag event strobe |
| flag_irq | output | 1 | Flag requests an interrupt |
| flag_info | output | 8 | Flag information byte |
| bad_cmd | output | 1 | Invalid opcode pulse |

## Verification
The bench fills the buffer behind an invalid header and then writes a flag header as the tenth word. A design that wrapped or overwrote on overflow would emit a flag instead of another invalid pulse. It writes a word on the very edge where a command clears the buffer, which catches a parser that loses that word or leaves stale words at the front. A data request is acknowledged with an error while an extra word is written during the busy period. A design that cleared on failure, or decoded during busy, would dispatch a spurious flag or drop the retried job. Key commands cover every length code, built-in selects and illegal modes, where a wrong payload count either fires early with a partial key or never fires.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int IV_WORDS  = 4;
  localparam int DATA_ARGS = 3;
  localparam int SIV_ARGS  = 1;

  typedef enum logic [3:0] {
    OP_KEY  = 4'h1,
    OP_IV   = 4'h2,
    OP_DATA = 4'h5,
    OP_SIV  = 4'h6,
    OP_FLAG = 4'h8
  } opcode_e;

  typedef enum logic [2:0] {
    ACT_WAIT, ACT_KEY, ACT_IV, ACT_DATA, ACT_SIV, ACT_FLAG, ACT_BAD
  } act_e;

  // payload words an explicit key needs; 0 marks an unsupported length
  function automatic int key_payload(input logic [1:0] code);
    case (code)
      2'd0:    return 4;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [47:0] data_src(input logic [31:0] hi_word,
                                           input logic [31:0] lo_word);
    return {hi_word[31:16], lo_word};
  endfunction

  function automatic logic [47:0] data_dst(input logic [31:0] hi_word,
                                           input logic [31:0] lo_word);
    return {hi_word[15:0], lo_word};
  endfunction

  function automatic logic [39:0] store_addr(input logic [7:0]  top_byte,
                                             input logic [31:0] lo_word);
    return {top_byte, lo_word};
  endfunction
endpackage

// File: rtl/cfp_cmd_buf.sv
module cfp_cmd_buf #(
  parameter int DEPTH = 9,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [31:0]            wr_data,
  input  logic                   clr,
  output logic [DEPTH-1:0][31:0] words,
  output logic [CNT_W-1:0]       count,
  output logic                   try_q,
  output logic                   drop
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] base;

  // a completing command empties the buffer before this edge's word lands
  assign base = clr ? '0 : count;
  assign drop = wr_valid && (base == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
      count <= '0;
      try_q <= 1'b0;
    end else begin
      try_q <= wr_valid;
      if (wr_valid && (base < FULL)) begin
        words[base] <= wr_data;
        count       <= base + 1'b1;
      end else begin
        count <= base;
      end
    end
  end
endmodule

// File: rtl/cfp_decode.sv
module cfp_decode
  import cfp_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int CNT_W = 4
) (
  input  logic [DEPTH-1:0][31:0]    words,
  input  logic [CNT_W-1:0]          count,
  output act_e                      act,
  output logic [27:0]               hdr_lo,
  output logic [31:0]               arg1,
  output logic [31:0]               arg2,
  output logic [31:0]               arg3,
  output logic [KEY_WORDS*32-1:0]   key_data,
  output logic [IV_WORDS*32-1:0]    iv_data
);
  logic [31:0] hdr;
  logic        builtin;
  int          have;
  int          kw;

  assign hdr     = words[0];
  assign hdr_lo  = hdr[27:0];
  assign arg1    = words[1];
  assign arg2    = words[2];
  assign arg3    = words[3];
  assign builtin = (hdr[26:24] != 3'd0);

  always_comb begin
    have = int'(count);
    kw   = key_payload(hdr[23:22]);
    act  = ACT_WAIT;
    if (have != 0) begin
      case (hdr[31:28])
        OP_KEY:  if (!hdr[17]) begin
                   if (builtin) act = ACT_KEY;
                   else if (kw != 0 && have >= kw + 1) act = ACT_KEY;
                 end
        OP_IV:   if (have >= IV_WORDS + 1)  act = ACT_IV;
        OP_DATA: if (have >= DATA_ARGS + 1) act = ACT_DATA;
        OP_SIV:  if (have >= SIV_ARGS + 1)  act = ACT_SIV;
        OP_FLAG: act = ACT_FLAG;
        default: act = ACT_BAD;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < KEY_WORDS; k++) begin
      key_data[32*k +: 32] = '0;
      if (!builtin && k < kw && k + 1 < DEPTH) key_data[32*k +: 32] = words[k+1];
    end
    for (int k = 0; k < IV_WORDS; k++) begin
      iv_data[32*k +: 32] = words[k+1];
    end
  end
endmodule

// File: rtl/cfp_dispatch.sv
module cfp_dispatch
  import cfp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  act_e                    act,
  input  logic [27:0]             hdr_lo,
  input  logic [31:0]             arg1,
  input  logic [31:0]             arg2,
  input  logic [31:0]             arg3,
  input  logic [KEY_WORDS*32-1:0] key_data_in,
  input  logic [IV_WORDS*32-1:0]  iv_data_in,
  input  logic                    dma_ack,
  input  logic                    dma_ok,
  input  logic                    siv_ack,
  input  logic                    siv_ok,
  output logic                    key_valid,
  output logic                    key_ctx,
  output logic [2:0]              key_sel,
  output logic [1:0]              key_len_code,
  output logic                    key_encrypt,
  output logic                    key_cbc,
  output logic [KEY_WORDS*32-1:0] key_data,
  output logic                    iv_valid,
  output logic [1:0]              iv_ctx,
  output logic [IV_WORDS*32-1:0]  iv_data,
  output logic                    dma_valid,
  output logic [23:0]             dma_len,
  output logic [47:0]             dma_src,
  output logic [47:0]             dma_dst,
  output logic                    dma_key_ctx,
  output logic [1:0]              dma_iv_ctx,
  output logic                    siv_valid,
  output logic [1:0]              siv_ctx,
  output logic [39:0]             siv_addr,
  output logic                    flag_valid,
  output logic                    flag_irq,
  output logic [7:0]              flag_info,
  output logic                    bad_cmd,
  output logic                    clr,
  output logic                    busy
);
  act_e fire;
  logic dma_done;
  logic siv_done;

  assign fire     = go ? act : ACT_WAIT;
  assign dma_done = dma_valid && dma_ack;
  assign siv_done = siv_valid && siv_ack;
  assign busy     = dma_valid || siv_valid;
  assign clr      = (fire == ACT_KEY) || (fire == ACT_IV) || (fire == ACT_FLAG) ||
                    (dma_done && dma_ok) || (siv_done && siv_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_valid <= 1'b0; key_ctx <= 1'b0; key_sel <= '0; key_len_code <= '0;
      key_encrypt <= 1'b0; key_cbc <= 1'b0; key_data <= '0;
      iv_valid <= 1'b0; iv_ctx <= '0; iv_data <= '0;
      dma_valid <= 1'b0; dma_len <= '0; dma_src <= '0; dma_dst <= '0;
      dma_key_ctx <= 1'b0; dma_iv_ctx <= '0;
      siv_valid <= 1'b0; siv_ctx <= '0; siv_addr <= '0;
      flag_valid <= 1'b0; flag_irq <= 1'b0; flag_info <= '0;
      bad_cmd <= 1'b0;
    end else begin
      key_valid  <= (fire == ACT_KEY);
      iv_valid   <= (fire == ACT_IV);
      flag_valid <= (fire == ACT_FLAG);
      bad_cmd    <= (fire == ACT_BAD);

      if (fire == ACT_KEY) begin
        key_ctx      <= hdr_lo[27];
        key_sel      <= hdr_lo[26:24];
        key_len_code <= hdr_lo[23:22];
        key_encrypt  <= hdr_lo[20];
        key_cbc      <= hdr_lo[16];
        key_data     <= key_data_in;
      end
      if (fire == ACT_IV) begin
        iv_ctx  <= hdr_lo[27:26];
        iv_data <= iv_data_in;
      end
      if (fire == ACT_FLAG) begin
        flag_irq  <= hdr_lo[27];
        flag_info <= hdr_lo[7:0];
      end

      if (fire == ACT_DATA) begin
        dma_valid   <= 1'b1;
        dma_len     <= hdr_lo[23:0];
        dma_key_ctx <= hdr_lo[27];
        dma_iv_ctx  <= hdr_lo[26:25];
        dma_src     <= data_src(arg1, arg2);
        dma_dst     <= data_dst(arg1, arg3);
      end else if (dma_done) begin
        dma_valid <= 1'b0;
      end

      if (fire == ACT_SIV) begin
        siv_valid <= 1'b1;
        siv_ctx   <= hdr_lo[27:26];
        siv_addr  <= store_addr(hdr_lo[7:0], arg1);
      end else if (siv_done) begin
        siv_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_fifo_parser.sv
module cmd_fifo_parser
  import cfp_pkg::*;
#(
  parameter int DEPTH = 9   // must leave room for a header and an 8-word key
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [31:0]             wr_data,
  output logic                    key_valid,
  output logic                    key_ctx,
  output logic [2:0]              key_sel,
  output logic [1:0]              key_len_code,
  output logic                    key_encrypt,
  output logic                    key_cbc,
  output logic [KEY_WORDS*32-1:0] key_data,
  output logic                    iv_valid,
  output logic [1:0]              iv_ctx,
  output logic [IV_WORDS*32-1:0]  iv_data,
  output logic                    dma_valid,
  input  logic                    dma_ack,
  input  logic                    dma_ok,
  output logic [23:0]             dma_len,
  output logic [47:0]             dma_src,
  output logic [47:0]             dma_dst,
  output logic                    dma_key_ctx,
  output logic [1:0]              dma_iv_ctx,
  output logic                    siv_valid,
  input  logic                    siv_ack,
  input  logic                    siv_ok,
  output logic [1:0]              siv_ctx,
  output logic [39:0]             siv_addr,
  output logic                    flag_valid,
  output logic                    flag_irq,
  output logic [7:0]              flag_info,
  output logic                    bad_cmd
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // named internal events, also watched by the bound checker
  logic [DEPTH-1:0][31:0]    words;
  logic [CNT_W-1:0]          count;
  logic                      try_q;
  logic                      drop;
  logic                      clr;
  logic                      busy;
  logic                      go;
  act_e                      act;
  logic [27:0]               hdr_lo;
  logic [31:0]               arg1, arg2, arg3;
  logic [KEY_WORDS*32-1:0]   key_data_c;
  logic [IV_WORDS*32-1:0]    iv_data_c;

  assign go = try_q && !busy;

  cfp_cmd_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .clr(clr), .words(words), .count(count), .try_q(try_q), .drop(drop)
  );

  cfp_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dec (
    .words(words), .count(count), .act(act), .hdr_lo(hdr_lo),
    .arg1(arg1), .arg2(arg2), .arg3(arg3),
    .key_data(key_data_c), .iv_data(iv_data_c)
  );

  cfp_dispatch u_disp (
    .clk(clk), .rst_n(rst_n), .go(go), .act(act), .hdr_lo(hdr_lo),
    .arg1(arg1), .arg2(arg2), .arg3(arg3),
    .key_data_in(key_data_c), .iv_data_in(iv_data_c),
    .dma_ack(dma_ack), .dma_ok(dma_ok), .siv_ack(siv_ack), .siv_ok(siv_ok),
    .key_valid(key_valid), .key_ctx(key_ctx), .key_sel(key_sel),
    .key_len_code(key_len_code), .key_encrypt(key_encrypt), .key_cbc(key_cbc),
    .key_data(key_data), .iv_valid(iv_valid), .iv_ctx(iv_ctx), .iv_data(iv_data),
    .dma_valid(dma_valid), .dma_len(dma_len), .dma_src(dma_src), .dma_dst(dma_dst),
    .dma_key_ctx(dma_key_ctx), .dma_iv_ctx(dma_iv_ctx),
    .siv_valid(siv_valid), .siv_ctx(siv_ctx), .siv_addr(siv_addr),
    .flag_valid(flag_valid), .flag_irq(flag_irq), .flag_info(flag_info),
    .bad_cmd(bad_cmd), .clr(clr), .busy(busy)
  );
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int DEPTH = 9,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             drop,
  input logic             go,
  input logic             clr,
  input logic             busy,
  input logic             key_valid,
  input logic             iv_valid,
  input logic             flag_valid,
  input logic             bad_cmd,
  input logic             dma_valid,
  input logic             dma_ack,
  input logic [47:0]      dma_src,
  input logic             siv_valid
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R1
  drop_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> int'(count) == DEPTH);

  // R2
  bad_keeps_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> count != '0);

  // R3
  strobe_follows_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid || iv_valid || flag_valid || bad_cmd) |-> $past(go));

  // R8
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ack) |=> (dma_valid && $stable(dma_src)));

  // R11
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> int'(count) <= 1);

  // R12
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(key_valid || iv_valid || flag_valid || bad_cmd));

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_valid, iv_valid, flag_valid, bad_cmd}) && !(dma_valid && siv_valid));
endmodule

bind cmd_fifo_parser cfp_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cfp_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .drop(drop), .go(go), .clr(clr),
  .busy(busy), .key_valid(key_valid), .iv_valid(iv_valid),
  .flag_valid(flag_valid), .bad_cmd(bad_cmd), .dma_valid(dma_valid),
  .dma_ack(dma_ack), .dma_src(dma_src), .siv_valid(siv_valid)
);

// File: tb/test_cmd_fifo_parser.sv
module test_cmd_fifo_parser;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic dma_ack = 1'b0, dma_ok = 1'b0, siv_ack = 1'b0, siv_ok = 1'b0;

  logic key_valid, key_ctx, key_encrypt, key_cbc;
  logic [2:0] key_sel;
  logic [1:0] key_len_code;
  logic [255:0] key_data;
  logic iv_valid;
  logic [1:0] iv_ctx;
  logic [127:0] iv_data;
  logic dma_valid, dma_key_ctx;
  logic [23:0] dma_len;
  logic [47:0] dma_src, dma_dst;
  logic [1:0] dma_iv_ctx;
  logic siv_valid;
  logic [1:0] siv_ctx;
  logic [39:0] siv_addr;
  logic flag_valid, flag_irq;
  logic [7:0] flag_info;
  logic bad_cmd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_fifo_parser i_cmd_fifo_parser (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .key_valid(key_valid), .key_ctx(key_ctx), .key_sel(key_sel),
    .key_len_code(key_len_code), .key_encrypt(key_encrypt), .key_cbc(key_cbc),
    .key_data(key_data), .iv_valid(iv_valid), .iv_ctx(iv_ctx), .iv_data(iv_data),
    .dma_valid(dma_valid), .dma_ack(dma_ack), .dma_ok(dma_ok), .dma_len(dma_len),
    .dma_src(dma_src), .dma_dst(dma_dst), .dma_key_ctx(dma_key_ctx),
    .dma_iv_ctx(dma_iv_ctx), .siv_valid(siv_valid), .siv_ack(siv_ack),
    .siv_ok(siv_ok), .siv_ctx(siv_ctx), .siv_addr(siv_addr),
    .flag_valid(flag_valid), .flag_irq(flag_irq), .flag_info(flag_info),
    .bad_cmd(bad_cmd)
  );

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 0;

  // ---------------- reference model ----------------
  logic [31:0] q[$];
  bit m_try;
  logic e_key_valid, e_key_ctx, e_key_encrypt, e_key_cbc;
  logic [2:0] e_key_sel; logic [1:0] e_key_len_code; logic [255:0] e_key_data;
  logic e_iv_valid; logic [1:0] e_iv_ctx; logic [127:0] e_iv_data;
  logic e_dma_valid, e_dma_key_ctx; logic [23:0] e_dma_len;
  logic [47:0] e_dma_src, e_dma_dst; logic [1:0] e_dma_iv_ctx;
  logic e_siv_valid; logic [1:0] e_siv_ctx; logic [39:0] e_siv_addr;
  logic e_flag_valid, e_flag_irq; logic [7:0] e_flag_info; logic e_bad_cmd;

  always @(posedge clk) begin
    bit wipe;
    bit was_busy;
    logic [31:0] h;
    int n;
    longint unsigned a;
    wipe = 0;
    if (!rst_n) begin
      q.delete(); m_try = 0;
      e_key_valid = 0; e_key_ctx = 0; e_key_encrypt = 0; e_key_cbc = 0;
      e_key_sel = 0; e_key_len_code = 0; e_key_data = 0;
      e_iv_valid = 0; e_iv_ctx = 0; e_iv_data = 0;
      e_dma_valid = 0; e_dma_key_ctx = 0; e_dma_len = 0; e_dma_src = 0;
      e_dma_dst = 0; e_dma_iv_ctx = 0;
      e_siv_valid = 0; e_siv_ctx = 0; e_siv_addr = 0;
      e_flag_valid = 0; e_flag_irq = 0; e_flag_info = 0; e_bad_cmd = 0;
    end else begin
      was_busy = e_dma_valid || e_siv_valid;
      e_key_valid = 0; e_iv_valid = 0; e_flag_valid = 0; e_bad_cmd = 0;
      if (e_dma_valid && dma_ack) begin e_dma_valid = 0; if (dma_ok) wipe = 1; end
      if (e_siv_valid && siv_ack) begin e_siv_valid = 0; if (siv_ok) wipe = 1; end
      if (m_try && !was_busy && q.size() > 0) begin
        h = q[0];
        case (h[31:28])
          4'h1: if (h[17:16] < 2) begin
                  n = (h[26:24] != 0) ? 0 : (h[23:22] == 3 ? -1 : 4 + 2 * h[23:22]);
                  if (n >= 0 && q.size() >= n + 1) begin
                    e_key_valid = 1; e_key_ctx = h[27]; e_key_sel = h[26:24];
                    e_key_len_code = h[23:22]; e_key_encrypt = h[20]; e_key_cbc = h[16];
                    e_key_data = 0;
                    for (int k = 0; k < n; k++) e_key_data[32*k +: 32] = q[k+1];
                    wipe = 1;
                  end
                end
          4'h2: if (q.size() >= 5) begin
                  e_iv_valid = 1; e_iv_ctx = h[27:26];
                  for (int k = 0; k < 4; k++) e_iv_data[32*k +: 32] = q[k+1];
                  wipe = 1;
                end
          4'h5: if (q.size() >= 4) begin
                  e_dma_valid = 1; e_dma_len = h[23:0]; e_dma_key_ctx = h[27];
                  e_dma_iv_ctx = h[26:25];
                  a = ((longint'(q[1]) >> 16) << 32) | longint'(q[2]);
                  e_dma_src = a[47:0];
                  a = ((longint'(q[1]) & 64'hFFFF) << 32) | longint'(q[3]);
                  e_dma_dst = a[47:0];
                end
          4'h6: if (q.size() >= 2) begin
                  e_siv_valid = 1; e_siv_ctx = h[27:26];
                  a = ((longint'(h) & 64'hFF) << 32) | longint'(q[1]);
                  e_siv_addr = a[39:0];
                end
          4'h8: begin
                  e_flag_valid = 1; e_flag_irq = h[27]; e_flag_info = h[7:0]; wipe = 1;
                end
          default: e_bad_cmd = 1;
        endcase
      end
      if (wipe) q.delete();
      if (wr_valid && q.size() < CAP) q.push_back(wr_data);
      m_try = wr_valid;
    end
  end

  task automatic cmp(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    cmp("R2 bad_cmd", 256'(bad_cmd), 256'(e_bad_cmd));
    cmp("R4 key_valid", 256'(key_valid), 256'(e_key_valid));
    cmp("R4 key fields", 256'({key_ctx, key_sel, key_len_code, key_encrypt, key_cbc}),
        256'({e_key_ctx, e_key_sel, e_key_len_code, e_key_encrypt, e_key_cbc}));
    cmp("R4 key_data", key_data, e_key_data);
    cmp("R6 iv_valid", 256'(iv_valid), 256'(e_iv_valid));
    cmp("R6 iv fields", 256'({iv_ctx, iv_data}), 256'({e_iv_ctx, e_iv_data}));
    cmp("R8 dma_valid", 256'(dma_valid), 256'(e_dma_valid));
    cmp("R7 dma descriptor", 256'({dma_len, dma_src, dma_dst, dma_key_ctx, dma_iv_ctx}),
        256'({e_dma_len, e_dma_src, e_dma_dst, e_dma_key_ctx, e_dma_iv_ctx}));
    cmp("R9 siv", 256'({siv_valid, siv_ctx, siv_addr}), 256'({e_siv_valid, e_siv_ctx, e_siv_addr}));
    cmp("R10 flag", 256'({flag_valid, flag_irq, flag_info}),
        256'({e_flag_valid, e_flag_irq, e_flag_info}));
  end

  // ---------------- acknowledge responders ----------------
  int dma_lat = 1, siv_lat = 1, dma_cnt = 0, siv_cnt = 0;
  bit dma_fail_next = 0, siv_fail_next = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dma_ack = 0; siv_ack = 0; dma_cnt = 0; siv_cnt = 0;
    end else begin
      if (dma_ack) dma_ack = 0;
      else if (dma_valid) begin
        if (dma_cnt >= dma_lat) begin
          dma_ack = 1; dma_ok = !dma_fail_next; dma_fail_next = 0; dma_cnt = 0;
        end else dma_cnt++;
      end
      if (siv_ack) siv_ack = 0;
      else if (siv_valid) begin
        if (siv_cnt >= siv_lat) begin
          siv_ack = 1; siv_ok = !siv_fail_next; siv_fail_next = 0; siv_cnt = 0;
        end else siv_cnt++;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [31:0] w);
    @(negedge clk); wr_valid = 1; wr_data = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); wr_valid = 0; end
  endtask

  task automatic settle();
    idle(3);
    while (dma_valid || siv_valid) @(negedge clk);
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_valid = 0;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  bit done = 0;

  initial begin
    idle(1);
    chk_on = 1;                        // reset state compared from here on
    idle(2);
    rst_n = 1;
    idle(2);

    // R10: flags with and without the interrupt request
    put(32'h8800_00A5); idle(3);
    put(32'h8000_0011); idle(3);

    // R11 R3: back-to-back flags, then an IV load right behind them
    put(32'h8000_0001); put(32'h8800_0002); put(32'h8000_0003);
    // R6: IV context 2, four payload words
    put(32'h2800_0000); put(32'h1111_0001); put(32'h2222_0002);
    put(32'h3333_0003); put(32'h4444_0004); idle(3);

    // R4: built-in key select, no payload
    put(32'h1B11_0000); idle(3);
    // R4: explicit keys of 4, 6 and 8 words
    put(32'h1000_0000);
    for (int i = 0; i < 4; i++) put(32'hA000_0000 + i);
    idle(3);
    put(32'h1041_0000);
    for (int i = 0; i < 6; i++) put(32'hB000_0000 + i);
    idle(3);
    put(32'h1890_0000);
    for (int i = 0; i < 8; i++) put(32'hC000_0000 + i);
    idle(3);

    // R5: illegal block mode never completes
    put(32'h1002_0000);
    for (int i = 0; i < 6; i++) put(32'hD000_0000 + i);
    idle(3);
    do_reset();
    // R5: explicit 64-byte key never completes
    put(32'h10C0_0000);
    for (int i = 0; i < 10; i++) put(32'hE000_0000 + i);
    idle(3);
    do_reset();

    // R1 R2: invalid header fills buffer; tenth word (a flag) is dropped
    put(32'h3000_0000);
    for (int i = 0; i < 8; i++) put(32'h0);
    put(32'h8000_0001); idle(2);
    put(32'h8000_0002); idle(3);
    do_reset();

    // R7 R8: data job accepted after a delay
    dma_lat = 3;
    put(32'h5A00_0100); put(32'h1234_ABCD); put(32'h1000_0000); put(32'h2000_0040);
    settle();

    // R8 R12: failed job, word written while busy, retry on next write
    dma_lat = 6; dma_fail_next = 1;
    put(32'h5000_0020); put(32'hFFFF_0001); put(32'h0000_1000); put(32'h0000_2000);
    put(32'h8800_0077);
    idle(12);
    dma_lat = 1;
    put(32'h0); settle();

    // R9: store IV, first with an error, then retried
    siv_lat = 2; siv_fail_next = 1;
    put(32'h6C00_00F3); put(32'hCAFE_0010); idle(8);
    put(32'hFFFF_FFFF); settle();

    // mixed stream of well-formed commands
    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = $urandom_range(0, 4);
      case (kind)
        0: begin
             logic [2:0] sel; logic [1:0] code; int n;
             sel = ($urandom_range(0, 1) == 1) ? 3'($urandom_range(1, 7)) : 3'd0;
             code = 2'($urandom_range(0, 2));
             n = (sel != 0) ? 0 : 4 + 2 * code;
             put({4'h1, 1'($urandom), sel, code, 1'b0, 1'($urandom), 2'b00, 1'b0,
                  1'($urandom), 16'h0});
             for (int i = 0; i < n; i++) put($urandom);
           end
        1: begin
             put({4'h2, 2'($urandom), 26'h0});
             for (int i = 0; i < 4; i++) put($urandom);
           end
        2: begin
             dma_lat = $urandom_range(0, 4);
             put({4'h5, 1'($urandom), 2'($urandom), 1'b0, 24'($urandom)});
             for (int i = 0; i < 3; i++) put($urandom);
           end
        3: begin
             siv_lat = $urandom_range(0, 4);
             put({4'h6, 2'($urandom), 18'h0, 8'($urandom)});
             put($urandom);
           end
        default: put({4'h8, 3'b000, 1'($urandom), 16'h0, 8'($urandom)});
      endcase
      settle();
    end

    idle(5);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule